// File: doc/BRIEF.md
# Channel-Mapped Priority DMA Arbiter

This block chooses which of twelve DMA requesters gets the memory bus in each cycle. Every requester owns a channel number, and the lowest channel number wins. Requesters 0 to 7 are peripheral streams. Software can move them between channels 0 to 7. Requesters 8 to 11 are the four memory-to-memory streams, and they always keep channels 8 to 11. The memory streams therefore always sit below every peripheral stream in priority.

The channel assignment changes only through a pair write. One command gives new channel numbers to two peripherals at the same time. The write is accepted only if the two new numbers are the two old numbers, either kept or exchanged. Both peripherals must also be disabled in that cycle. Any other write leaves the map untouched and sets a sticky error flag.

The grant is registered and lasts for one cycle. The arbiter runs again in every cycle, so a requester that keeps its request asserted is granted again and again until a higher-priority requester appears.

Top module: `chmap_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `gnt_o` is zero, `gnt_vld_o` is 0 and `map_err_o` is 0. After reset, every requester p is on channel p.
- R2: The request and enable inputs are sampled at a clock edge. One cycle later, `gnt_o` has exactly one bit set: the bit of the active requester (request and enable both 1) that holds the lowest channel number. If no requester is active, `gnt_o` is zero.
- R3: A request from a requester whose enable bit is 0 is never granted, and it does not block a lower-priority requester.
- R4: `gnt_o` is one-hot or zero. `gnt_vld_o` is 1 exactly when `gnt_o` is non-zero. When `gnt_vld_o` is 1, `gnt_idx_o` is the bit position set in `gnt_o`.
- R5: Requesters 8 to 11 stay on channels 8 to 11 in every state. A pair write that names a requester index of 8 or more is rejected.
- R6: A pair write (`mapw_i`=1, requester indices `mapw_pa_i`/`mapw_pb_i`, new channels `mapw_ca_i`/`mapw_cb_i`) is accepted when all of these hold:
  - both indices are below 8 and different from each other;
  - both enable bits are 0 in that cycle;
  - the new channels equal the pair's current channels, either as they are or exchanged.
  An accepted write takes effect for requests sampled from the next clock edge on.
- R7: A pair write that names a requester whose enable bit is 1 is rejected. The map stays unchanged, and `map_err_o` is 1 from the following cycle.
- R8: A pair write that would give two requesters the same channel, or would give a peripheral a channel outside 0 to 7, is rejected. The map stays unchanged and `map_err_o` is set.
- R9: Once set, `map_err_o` stays 1 until reset.
- R10: Arbitration runs in every cycle. A requester that holds its request is granted in each cycle, until an active requester with a lower channel number takes the grant on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 12 | Per-requester request |
| en_i | input | 12 | Per-requester enable |
| mapw_i | input | 1 | Pair map write strobe |
| mapw_pa_i | input | 4 | First requester index of the pair |
| mapw_ca_i | input | 4 | New channel for the first requester |
| mapw_pb_i | input | 4 | Second requester index of the pair |
| mapw_cb_i | input | 4 | New channel for the second requester |
| gnt_o | output | 12 | One-hot grant, one bit per requester |
| gnt_vld_o | output | 1 | A grant is present |
| gnt_idx_o | output | 4 | Index of the granted requester |
| map_err_o | output | 1 | Sticky rejected-write flag |

## Verification
The main function is driven with several kinds of stimulus:
- All requesters active at once, which shows that channel 0 wins.
- Sparse pairs that straddle the peripheral and memory boundary, which separate peripherals from the pinned memory streams.
- A held request that is later overtaken by a higher-priority one, which shows that arbitration runs again every cycle.
- Active requests combined with cleared enables, which separate a raw request from an active one.

After an exchange of channels, pairs of requests whose order depends only on the new map show whether the write took effect. After each kind of rejected write (enabled requester, duplicate channel, out-of-range index), the same kind of pair shows that the map did not change. A long random run of requests, enables and writes is then compared in every cycle against a behavioural model.

// File: rtl/chmap_pkg.sv
package chmap_pkg;
  parameter int unsigned NUM_CH    = 12;
  parameter int unsigned NUM_REMAP = 8;
  localparam int unsigned IDX_W    = $clog2(NUM_CH);

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [NUM_CH-1:0] vec_t;

  // lowest set position of a vector, zero when empty
  function automatic idx_t lowest_set(input vec_t v);
    idx_t r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) r = idx_t'(i);
    end
    return r;
  endfunction

  // read one bit with a range-safe index
  function automatic logic bit_at(input vec_t v, input idx_t i);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (i == idx_t'(k)) r = v[k];
    end
    return r;
  endfunction

  // new pair of channels is the old pair, kept or exchanged
  function automatic logic same_pair(input idx_t old_a, input idx_t old_b,
                                     input idx_t new_a, input idx_t new_b);
    return ((new_a == old_a) && (new_b == old_b)) ||
           ((new_a == old_b) && (new_b == old_a));
  endfunction

  function automatic logic remappable(input idx_t v);
    return v < idx_t'(NUM_REMAP);
  endfunction
endpackage

// File: rtl/chmap_table.sv
module chmap_table
  import chmap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  vec_t en_i,
  input  logic wr_i,
  input  idx_t pa_i,
  input  idx_t ca_i,
  input  idx_t pb_i,
  input  idx_t cb_i,
  output idx_t chan_o [NUM_CH],
  output logic accept_o,
  output logic reject_o,
  output logic err_o
);
  idx_t remap_q [NUM_REMAP];
  logic err_q;
  idx_t cur_a, cur_b;
  logic in_range, distinct, idle, perm;

  always_comb begin
    cur_a = '0;
    cur_b = '0;
    for (int i = 0; i < NUM_REMAP; i++) begin
      if (pa_i == idx_t'(i)) cur_a = remap_q[i];
      if (pb_i == idx_t'(i)) cur_b = remap_q[i];
    end
  end

  assign in_range = remappable(pa_i) && remappable(pb_i) &&
                    remappable(ca_i) && remappable(cb_i);
  assign distinct = (pa_i != pb_i);
  assign idle     = !bit_at(en_i, pa_i) && !bit_at(en_i, pb_i);
  assign perm     = same_pair(cur_a, cur_b, ca_i, cb_i);
  assign accept_o = wr_i && in_range && distinct && idle && perm;
  assign reject_o = wr_i && !accept_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REMAP; i++) remap_q[i] <= idx_t'(i);
      err_q <= 1'b0;
    end else begin
      if (accept_o) begin
        for (int i = 0; i < NUM_REMAP; i++) begin
          if (pa_i == idx_t'(i)) remap_q[i] <= ca_i;
          else if (pb_i == idx_t'(i)) remap_q[i] <= cb_i;
        end
      end
      if (reject_o) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  generate
    for (genvar p = 0; p < NUM_CH; p++) begin : g_chan
      if (p < NUM_REMAP) begin : g_soft
        assign chan_o[p] = remap_q[p];
      end else begin : g_pinned
        assign chan_o[p] = idx_t'(p);
      end
    end
  endgenerate
endmodule

// File: rtl/chmap_select.sv
module chmap_select
  import chmap_pkg::*;
(
  input  vec_t act_i,
  input  idx_t chan_i [NUM_CH],
  output logic win_any_o,
  output idx_t win_idx_o,
  output vec_t win_oh_o
);
  vec_t chreq;
  idx_t owner [NUM_CH];
  idx_t win_ch;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
      logic hit;
      idx_t who;
      always_comb begin
        hit = 1'b0;
        who = '0;
        for (int p = 0; p < NUM_CH; p++) begin
          if (act_i[p] && (chan_i[p] == idx_t'(c))) begin
            hit = 1'b1;
            who = idx_t'(p);
          end
        end
      end
      assign chreq[c] = hit;
      assign owner[c] = who;
    end
  endgenerate

  assign win_ch    = lowest_set(chreq);
  assign win_any_o = |chreq;

  always_comb begin
    win_idx_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (win_ch == idx_t'(c)) win_idx_o = owner[c];
    end
  end

  generate
    for (genvar p = 0; p < NUM_CH; p++) begin : g_oh
      assign win_oh_o[p] = win_any_o && (win_idx_o == idx_t'(p));
    end
  endgenerate
endmodule

// File: rtl/chmap_arbiter.sv
module chmap_arbiter
  import chmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              mapw_i,
  input  logic [IDX_W-1:0]  mapw_pa_i,
  input  logic [IDX_W-1:0]  mapw_ca_i,
  input  logic [IDX_W-1:0]  mapw_pb_i,
  input  logic [IDX_W-1:0]  mapw_cb_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              gnt_vld_o,
  output logic [IDX_W-1:0]  gnt_idx_o,
  output logic              map_err_o
);
  vec_t act;
  idx_t chan_map [NUM_CH];
  logic wr_accept, wr_reject;
  logic win_any;
  idx_t win_idx;
  vec_t win_oh;
  vec_t gnt_q;
  logic vld_q;
  idx_t idx_q;

  assign act = req_i & en_i;

  chmap_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .wr_i     (mapw_i),
    .pa_i     (mapw_pa_i),
    .ca_i     (mapw_ca_i),
    .pb_i     (mapw_pb_i),
    .cb_i     (mapw_cb_i),
    .chan_o   (chan_map),
    .accept_o (wr_accept),
    .reject_o (wr_reject),
    .err_o    (map_err_o)
  );

  chmap_select u_select (
    .act_i     (act),
    .chan_i    (chan_map),
    .win_any_o (win_any),
    .win_idx_o (win_idx),
    .win_oh_o  (win_oh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= '0;
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      gnt_q <= win_oh;
      vld_q <= win_any;
      idx_q <= win_idx;
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_vld_o = vld_q;
  assign gnt_idx_o = idx_q;
endmodule

// File: rtl/chmap_arbiter_chk.sv
module chmap_arbiter_chk
  import chmap_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input vec_t req_i,
  input vec_t en_i,
  input vec_t gnt_o,
  input logic gnt_vld_o,
  input idx_t gnt_idx_o,
  input logic map_err_o,
  input logic wr_accept,
  input logic wr_reject
);
  localparam vec_t SOFT_MASK = vec_t'((1 << NUM_REMAP) - 1);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R4
  AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o == (gnt_o != '0)); // R4
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> bit_at(gnt_o, gnt_idx_o)); // R4
  AST_GNT_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> (($past(req_i) & $past(en_i) & gnt_o) != '0)); // R3
  AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i & en_i) == '0) |=> !gnt_vld_o); // R2
  AST_MEM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld_o && !remappable(gnt_idx_o)) |->
      (($past(req_i) & $past(en_i) & SOFT_MASK) == '0)); // R5
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> map_err_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    map_err_o |=> map_err_o); // R9
  AST_ACCEPT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !map_err_o) |=> !map_err_o); // R6
endmodule

bind chmap_arbiter chmap_arbiter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .en_i      (en_i),
  .gnt_o     (gnt_o),
  .gnt_vld_o (gnt_vld_o),
  .gnt_idx_o (gnt_idx_o),
  .map_err_o (map_err_o),
  .wr_accept (wr_accept),
  .wr_reject (wr_reject)
);

// File: tb/test_chmap_arbiter.sv
module test_chmap_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] req, en;
  logic        mapw;
  logic [3:0]  pa, ca, pb, cb;
  logic [11:0] gnt;
  logic        gvld;
  logic [3:0]  gidx;
  logic        merr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int mchan [12];
  bit merr;

  always #4 clk = ~clk;

  chmap_arbiter i_chmap_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en),
    .mapw_i(mapw), .mapw_pa_i(pa), .mapw_ca_i(ca),
    .mapw_pb_i(pb), .mapw_cb_i(cb),
    .gnt_o(gnt), .gnt_vld_o(gvld), .gnt_idx_o(gidx), .map_err_o(merr_o)
  );

  task automatic compare(input string tag, input logic [11:0] eg, input bit ev,
                         input int ei, input bit ee);
    total++;
    if (gnt !== eg || gvld !== ev || (ev && gidx !== 4'(ei)) || merr_o !== ee) begin
      bad++;
      $display("FAIL %s: gnt=%h vld=%b idx=%0d err=%b expected gnt=%h vld=%b idx=%0d err=%b",
               tag, gnt, gvld, gidx, merr_o, eg, ev, ei, ee);
    end
  endtask

  // one clock: model predicts, design advances, outputs compared
  task automatic step(input string tag);
    int best, bestch;
    bit ok;
    int tmp [12];
    int seen [16];
    logic [11:0] eg;
    best = -1;
    bestch = 100;
    for (int p = 0; p < 12; p++)
      if (req[p] && en[p] && mchan[p] < bestch) begin
        bestch = mchan[p];
        best = p;
      end
    if (mapw) begin
      ok = (pa < 8) && (pb < 8) && (pa != pb) && (ca < 8) && (cb < 8);
      if (ok) ok = !en[pa] && !en[pb];
      if (ok) begin
        tmp = mchan;
        tmp[pa] = int'(ca);
        tmp[pb] = int'(cb);
        for (int k = 0; k < 12; k++) seen[tmp[k]]++;
        for (int v = 0; v < 16; v++) if (seen[v] > 1) ok = 0;
      end
      if (ok) mchan = tmp;
      else merr = 1;
    end
    eg = (best >= 0) ? (12'h1 << best) : 12'h0;
    @(posedge clk);
    #1;
    compare(tag, eg, best >= 0, best, merr);
  endtask

  task automatic do_reset();
    rst_n = 0; req = '0; en = '0; mapw = 0; pa = '0; ca = '0; pb = '0; cb = '0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 in reset", 12'h0, 0, 0, 0);
    rst_n = 1;
    for (int p = 0; p < 12; p++) mchan[p] = p;
    merr = 0;
  endtask

  task automatic wr(input int a, input int nca, input int b, input int ncb, input string tag);
    mapw = 1; pa = 4'(a); ca = 4'(nca); pb = 4'(b); cb = 4'(ncb);
    step(tag);
    mapw = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    step("R1 first cycle");
    en = 12'hFFF;
    req = 12'hFFF; step("R2 R4 all active");
    req = 12'h0A0; step("R2 pair 5,7");
    req = 12'h900; step("R5 memory 8,11");
    req = 12'h880; step("R5 peripheral 7 over memory 11");
    req = 12'hA00; step("R5 memory 9,11");
    en = 12'hFFE; req = 12'h081; step("R3 disabled 0 ignored");
    en = 12'hFFF;
    req = 12'h028; repeat (3) step("R10 held request 3");
    req = 12'h02A; step("R10 higher 1 overtakes");
    req = 12'h000; step("R2 idle");
    // exchange peripherals 0 and 7 while both are disabled
    en = 12'hF7E; wr(0, 7, 7, 0, "R6 swap 0,7");
    en = 12'hFFF;
    req = 12'h041; step("R6 0 now below 6");
    req = 12'h081; step("R6 7 now on top");
    en = 12'hFFF; wr(1, 2, 2, 1, "R7 enabled write");
    req = 12'h006; step("R7 map unchanged");
    repeat (20) step("R9 error held");
    do_reset();
    en = 12'h000; wr(3, 4, 4, 4, "R8 duplicate");
    en = 12'hFFF; req = 12'h018; step("R8 map unchanged 3,4");
    en = 12'h000; req = 12'h000; wr(3, 5, 4, 3, "R8 foreign channel");
    en = 12'hFFF; req = 12'h028; step("R8 map unchanged 3,5");
    en = 12'h000; req = 12'h000; wr(8, 2, 2, 8, "R5 pinned index");
    en = 12'hFFF; req = 12'h104; step("R5 map unchanged 2,8");
    en = 12'h000; req = 12'h000; wr(4, 4, 4, 4, "R8 same index");
    for (int n = 0; n < 3000; n++) begin
      req = 12'($urandom);
      en = 12'($urandom) & 12'($urandom);
      if (($urandom % 4) == 0) begin
        int a, b;
        a = int'($urandom % 9);
        b = int'($urandom % 9);
        if (($urandom % 5) != 0 && a < 8 && b < 8) wr(a, mchan[b], b, mchan[a], "R6 R7 R8 random write");
        else wr(a, int'($urandom % 16), b, int'($urandom % 16), "R8 random write");
      end else begin
        step("R2 R3 R10 random");
      end
      if (n == 1500) do_reset();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule